// File: doc/BRIEF.md
# NAND program command interpreter

This block is the device-side logic of one NAND flash die that follows the program sequence. It observes write cycles on an 8-bit I/O bus. Each cycle is marked as a command, an address or a data byte. From these cycles it builds a column pointer into the page cache and a row destination in the array. It writes incoming data bytes into the cache through a strobe, and it raises a one-cycle program-start pulse with a program type when the final command of a sequence arrives.

The opcode 85h has two meanings inside an open program sequence. If it is followed by two column cycles only, it moves the data-input pointer. If it is followed by two column cycles and then three row cycles, it also replaces the block and page destination. The opcode stays legal while a cache program runs in the background, which is signalled by `ardy` low with `rdy` high. Outside an open sequence, an 85h with the die fully idle opens an internal-data-move setup, and only 10h can close that setup.

Top module: `nand_prog_ctl`

## Requirements
- R1: After reset, `cache_we` and `prog_go` are 0, `row_addr` and `cache_addr` are 0, and `prog_kind` is 0.
- R2: Command 80h followed by five address cycles opens a program sequence. The cycles are column low byte, column high byte, then row bytes 0, 1 and 2, least significant first. The column is the low `COL_W` bits of the two column bytes, and the row is the low `ROW_W` bits of the three row bytes. Each later data cycle produces `cache_we`=1 in the next clock with `cache_addr` equal to the current column and `cache_wdata` equal to the byte. The column then advances by one.
- R3: Inside an open sequence, 85h followed by exactly two address cycles loads a new column and leaves `row_addr` unchanged. Data then continues at the new column.
- R4: Inside an open sequence, 85h followed by five address cycles loads a new column and replaces `row_addr` with the three row bytes. `row_addr` changes only in the clock after an accepted address cycle.
- R5: An 85h inside an open sequence is accepted while `ardy`=0 and `rdy`=1. An 85h with no sequence open and `ardy`=0 is ignored: the data and 10h that follow it produce no write and no program.
- R6: Every bus cycle presented while `rdy`=0 has no effect on the outputs or on the sequence.
- R7: A final command in an open sequence gives `prog_go`=1 for exactly one clock, in the clock after the command cycle. With the pulse, `prog_kind` is 0 for 10h, 1 for 15h and 2 for 11h. The sequence then closes.
- R8: An 85h followed by three or four address cycles and then a data byte or command is treated as column-only: the column changes and `row_addr` keeps its previous value.
- R9: With no sequence open and `rdy`=`ardy`=1, 85h plus five address cycles opens an internal-data-move setup. In that setup 10h starts a program of type 0, while 15h or 11h closes the setup without a program.
- R10: A command other than 80h, 85h, 10h, 11h or 15h during data input closes the sequence without a program. Data bytes after that are not written.
- R11: Data bytes are ignored until the column is complete. That means before the fifth address cycle of an 80h setup, or before the second address cycle after an 85h.
- R12: The column pointer wraps from 2^`COL_W`-1 to 0 on data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus write cycle is present this clock |
| bus_cmd | input | 1 | The cycle is a command |
| bus_addr | input | 1 | The cycle is an address byte |
| bus_io | input | 8 | Bus byte |
| rdy | input | 1 | Die ready for bus cycles |
| ardy | input | 1 | Array idle (low while a cache program runs) |
| cache_we | output | 1 | Cache write strobe |
| cache_addr | output | COL_W | Cache column of the write |
| cache_wdata | output | 8 | Cache write byte |
| row_addr | output | ROW_W | Program destination row |
| prog_go | output | 1 | Program-start pulse |
| prog_kind | output | 2 | Program type: 0 page, 1 cache, 2 multi-plane |

## Verification
The two functions that coincide are a background cache program, seen as `ardy` low, and an 85h redirection arriving in the same cycle. The bench first closes a sequence with 15h. It keeps `ardy` low, opens a new 80h sequence and redirects it with 85h while `ardy` stays low. The redirection is judged by the columns at which the scoreboard expects the following bytes. The same opcode is then sent with `ardy` low and no sequence open. Any write or program pulse that follows it is reported as an unexpected scoreboard item.

// File: rtl/nand_prog_pkg.sv
package nand_prog_pkg;

    localparam logic [7:0] OP_SETUP = 8'h80;
    localparam logic [7:0] OP_REDIR = 8'h85;
    localparam logic [7:0] OP_PAGE  = 8'h10;
    localparam logic [7:0] OP_MULTI = 8'h11;
    localparam logic [7:0] OP_CACHE = 8'h15;

    typedef enum logic [1:0] {
        PK_PAGE  = 2'd0,
        PK_CACHE = 2'd1,
        PK_MULTI = 2'd2
    } prog_kind_t;

    typedef enum logic [2:0] {
        OC_SETUP, OC_REDIR, OC_PAGE, OC_MULTI, OC_CACHE, OC_OTHER
    } opc_t;

    typedef enum logic [1:0] {
        EV_NONE, EV_CMD, EV_ADDR, EV_DATA
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t   kind;
        opc_t       opc;
        logic [7:0] byte_v;
    } bus_ev_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_ADRS, ST_DATA
    } seq_st_t;

    typedef struct packed {
        logic clr_cnt;
        logic take_addr;
        logic wr_data;
    } dp_ctl_t;

    function automatic opc_t classify(input logic [7:0] op);
        case (op)
            OP_SETUP: return OC_SETUP;
            OP_REDIR: return OC_REDIR;
            OP_PAGE:  return OC_PAGE;
            OP_MULTI: return OC_MULTI;
            OP_CACHE: return OC_CACHE;
            default:  return OC_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode
    import nand_prog_pkg::*;
(
    input  logic       bus_valid,
    input  logic       bus_cmd,
    input  logic       bus_addr,
    input  logic [7:0] bus_io,
    input  logic       rdy,
    output bus_ev_t    ev
);

    always_comb begin
        ev.kind   = EV_NONE;
        ev.opc    = OC_OTHER;
        ev.byte_v = bus_io;
        if (bus_valid && rdy) begin
            if (bus_cmd && !bus_addr) begin
                ev.kind = EV_CMD;
                ev.opc  = classify(bus_io);
            end else if (bus_addr && !bus_cmd) begin
                ev.kind = EV_ADDR;
            end else if (!bus_cmd && !bus_addr) begin
                ev.kind = EV_DATA;
            end
        end
    end

endmodule

// File: rtl/nand_addr_path.sv
module nand_addr_path
    import nand_prog_pkg::*;
#(
    parameter int COL_W     = 12,
    parameter int ROW_W     = 17,
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    localparam int ADDR_CYC = COL_BYTES + ROW_BYTES,
    localparam int CNT_W    = $clog2(ADDR_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_ctl_t          ctl,
    input  logic [7:0]       byte_v,
    output logic [CNT_W-1:0] cnt,
    output logic             cache_we,
    output logic [COL_W-1:0] cache_addr,
    output logic [7:0]       cache_wdata,
    output logic [ROW_W-1:0] row_addr
);

    localparam int CSW = 8 * COL_BYTES;
    localparam int RSW = 8 * ROW_BYTES;

    logic [CSW-1:0]   col_stage, col_ins;
    logic [RSW-1:0]   row_stage, row_ins;
    logic [COL_W-1:0] col_q;

    // Place the incoming byte into the staging word at the slot the count selects.
    always_comb begin
        col_ins = col_stage;
        row_ins = row_stage;
        for (int i = 0; i < COL_BYTES; i++)
            if (cnt == CNT_W'(i)) col_ins[8*i +: 8] = byte_v;
        for (int j = 0; j < ROW_BYTES; j++)
            if (cnt == CNT_W'(COL_BYTES + j)) row_ins[8*j +: 8] = byte_v;
    end

    generate
        if (CSW > COL_W) begin : g_col_trim
            logic unused_col_hi;
            assign unused_col_hi = ^col_ins[CSW-1:COL_W];
        end
        if (RSW > ROW_W) begin : g_row_trim
            logic unused_row_hi;
            assign unused_row_hi = ^row_ins[RSW-1:ROW_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            col_stage   <= '0;
            row_stage   <= '0;
            col_q       <= '0;
            row_addr    <= '0;
            cache_we    <= 1'b0;
            cache_addr  <= '0;
            cache_wdata <= '0;
        end else begin
            cache_we <= 1'b0;
            if (ctl.clr_cnt) begin
                cnt <= '0;
            end else if (ctl.take_addr) begin
                cnt       <= cnt + 1'b1;
                col_stage <= col_ins;
                row_stage <= row_ins;
                // column takes effect once its last byte is in
                if (cnt == CNT_W'(COL_BYTES - 1)) col_q <= col_ins[COL_W-1:0];
                // row is replaced only when every row byte has arrived
                if (cnt == CNT_W'(ADDR_CYC - 1)) row_addr <= row_ins[ROW_W-1:0];
            end
            if (ctl.wr_data) begin
                cache_we    <= 1'b1;
                cache_addr  <= col_q;
                cache_wdata <= byte_v;
                col_q       <= col_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_prog_pkg::*;
#(
    parameter int COL_BYTES = 2,
    parameter int ADDR_CYC  = 5,
    localparam int CNT_W    = $clog2(ADDR_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_kind_t         ev_kind,
    input  opc_t             ev_opc,
    input  logic             ardy,
    input  logic [CNT_W-1:0] cnt,
    output dp_ctl_t          ctl,
    output logic             prog_go,
    output prog_kind_t       prog_kind
);

    seq_st_t    st, st_n;
    logic       redir, redir_n;
    logic       move, move_n;
    logic       go_n;
    prog_kind_t kind_n;
    logic       col_done, addr_last, seq_cmd;

    assign col_done  = (cnt >= CNT_W'(COL_BYTES));
    assign addr_last = (cnt == CNT_W'(ADDR_CYC - 1));
    // commands that act on an open sequence: data input, or a pending redirection
    assign seq_cmd   = (ev_kind == EV_CMD) &&
                       (st == ST_DATA || (st == ST_ADRS && redir));

    always_comb begin
        st_n    = st;
        redir_n = redir;
        move_n  = move;
        ctl     = '0;
        go_n    = 1'b0;
        kind_n  = prog_kind;
        unique case (st)
            ST_IDLE: begin
                if (ev_kind == EV_CMD) begin
                    if (ev_opc == OC_SETUP) begin
                        st_n = ST_ADRS; redir_n = 1'b0; move_n = 1'b0; ctl.clr_cnt = 1'b1;
                    end else if (ev_opc == OC_REDIR && ardy) begin
                        st_n = ST_ADRS; redir_n = 1'b0; move_n = 1'b1; ctl.clr_cnt = 1'b1;
                    end
                end
            end
            ST_ADRS: begin
                if (ev_kind == EV_ADDR) begin
                    ctl.take_addr = 1'b1;
                    if (addr_last) st_n = ST_DATA;
                end else if (ev_kind == EV_DATA) begin
                    if (redir && col_done) begin
                        ctl.wr_data = 1'b1;
                        st_n = ST_DATA;
                    end
                end else if (ev_kind == EV_CMD && !redir) begin
                    if (ev_opc == OC_SETUP) begin
                        redir_n = 1'b0; move_n = 1'b0; ctl.clr_cnt = 1'b1;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (ev_kind == EV_DATA) ctl.wr_data = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase

        if (seq_cmd) begin
            unique case (ev_opc)
                OC_REDIR: begin
                    st_n = ST_ADRS; redir_n = 1'b1; ctl.clr_cnt = 1'b1;
                end
                OC_SETUP: begin
                    st_n = ST_ADRS; redir_n = 1'b0; move_n = 1'b0; ctl.clr_cnt = 1'b1;
                end
                OC_PAGE: begin
                    st_n = ST_IDLE; go_n = 1'b1; kind_n = PK_PAGE;
                end
                OC_CACHE: begin
                    st_n = ST_IDLE;
                    if (!move) begin go_n = 1'b1; kind_n = PK_CACHE; end
                end
                OC_MULTI: begin
                    st_n = ST_IDLE;
                    if (!move) begin go_n = 1'b1; kind_n = PK_MULTI; end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            redir     <= 1'b0;
            move      <= 1'b0;
            prog_go   <= 1'b0;
            prog_kind <= PK_PAGE;
        end else begin
            st        <= st_n;
            redir     <= redir_n;
            move      <= move_n;
            prog_go   <= go_n;
            prog_kind <= kind_n;
        end
    end

endmodule

// File: rtl/nand_prog_ctl.sv
module nand_prog_ctl
    import nand_prog_pkg::*;
#(
    parameter int COL_W     = 12,
    parameter int ROW_W     = 17,
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_cmd,
    input  logic             bus_addr,
    input  logic [7:0]       bus_io,
    input  logic             rdy,
    input  logic             ardy,
    output logic             cache_we,
    output logic [COL_W-1:0] cache_addr,
    output logic [7:0]       cache_wdata,
    output logic [ROW_W-1:0] row_addr,
    output logic             prog_go,
    output logic [1:0]       prog_kind
);

    localparam int ADDR_CYC = COL_BYTES + ROW_BYTES;
    localparam int CNT_W    = $clog2(ADDR_CYC + 1);

    bus_ev_t          ev;
    dp_ctl_t          ctl;
    logic [CNT_W-1:0] cnt;
    prog_kind_t       kind_w;

    nand_bus_decode u_dec (
        .bus_valid (bus_valid),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_io    (bus_io),
        .rdy       (rdy),
        .ev        (ev)
    );

    nand_seq_fsm #(.COL_BYTES(COL_BYTES), .ADDR_CYC(ADDR_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev_kind   (ev.kind),
        .ev_opc    (ev.opc),
        .ardy      (ardy),
        .cnt       (cnt),
        .ctl       (ctl),
        .prog_go   (prog_go),
        .prog_kind (kind_w)
    );

    nand_addr_path #(
        .COL_W(COL_W), .ROW_W(ROW_W), .COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)
    ) u_path (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .byte_v      (ev.byte_v),
        .cnt         (cnt),
        .cache_we    (cache_we),
        .cache_addr  (cache_addr),
        .cache_wdata (cache_wdata),
        .row_addr    (row_addr)
    );

    assign prog_kind = kind_w;

endmodule

// File: rtl/nand_prog_ctl_chk.sv
module nand_prog_ctl_chk #(
    parameter int COL_W = 12,
    parameter int ROW_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_cmd,
    input logic             bus_addr,
    input logic             rdy,
    input logic             cache_we,
    input logic [COL_W-1:0] cache_addr,
    input logic [ROW_W-1:0] row_addr,
    input logic             prog_go
);

    // R6
    busy_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> (!cache_we && !prog_go));

    // R7
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> !prog_go);

    // R7
    go_we_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(prog_go && cache_we));

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_we && $past(cache_we)) |-> (cache_addr == $past(cache_addr) + 1'b1));

    // R4
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_addr && !bus_cmd && rdy) |=> $stable(row_addr));

endmodule

bind nand_prog_ctl nand_prog_ctl_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .rdy        (rdy),
    .cache_we   (cache_we),
    .cache_addr (cache_addr),
    .row_addr   (row_addr),
    .prog_go    (prog_go)
);

// File: tb/sim_nand_prog_ctl.sv
module sim_nand_prog_ctl;

    localparam int COL_W = 12;
    localparam int ROW_W = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_valid = 1'b0, bus_cmd = 1'b0, bus_addr = 1'b0;
    logic [7:0]       bus_io = 8'h00;
    logic             rdy = 1'b1, ardy = 1'b1;
    logic             cache_we, prog_go;
    logic [COL_W-1:0] cache_addr;
    logic [7:0]       cache_wdata;
    logic [ROW_W-1:0] row_addr;
    logic [1:0]       prog_kind;

    always #4 clk = ~clk;

    nand_prog_ctl #(.COL_W(COL_W), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_io(bus_io), .rdy(rdy), .ardy(ardy),
        .cache_we(cache_we), .cache_addr(cache_addr), .cache_wdata(cache_wdata),
        .row_addr(row_addr), .prog_go(prog_go), .prog_kind(prog_kind)
    );

    typedef struct {
        bit               is_go;
        logic [COL_W-1:0] addr;
        logic [7:0]       data;
        logic [1:0]       kind;
        logic [ROW_W-1:0] row;
        string            req;
    } item_t;

    item_t            sb[$];
    int               n_chk = 0;
    int               n_bad = 0;
    logic [COL_W-1:0] exp_col;
    logic [ROW_W-1:0] exp_row = '0;
    bit               done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_cmd = c; bus_addr = a; bus_io = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_cmd = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op);  cyc(1'b1, 1'b0, op); endtask
    task automatic adr(input logic [7:0] b);   cyc(1'b0, 1'b1, b);  endtask
    task automatic dat(input logic [7:0] b);   cyc(1'b0, 1'b0, b);  endtask

    task automatic dat_exp(input logic [7:0] b, input string req);
        item_t it;
        it.is_go = 0; it.addr = exp_col; it.data = b; it.kind = 0; it.row = 0; it.req = req;
        sb.push_back(it);
        exp_col = exp_col + 1'b1;
        dat(b);
    endtask

    task automatic go_exp(input logic [7:0] op, input logic [1:0] k, input string req);
        item_t it;
        it.is_go = 1; it.addr = 0; it.data = 0; it.kind = k; it.row = exp_row; it.req = req;
        sb.push_back(it);
        cmd(op);
    endtask

    task automatic setup80(input logic [15:0] col, input logic [23:0] row);
        cmd(8'h80);
        adr(col[7:0]); adr(col[15:8]);
        adr(row[7:0]); adr(row[15:8]); adr(row[23:16]);
        exp_col = col[COL_W-1:0];
        exp_row = row[ROW_W-1:0];
    endtask

    // scoreboard monitor: every output event is matched against the queue
    always @(negedge clk) begin
        if (!rst && (cache_we || prog_go)) begin
            if (sb.size() == 0) begin
                check(0, "R5/R6/R9/R10/R11", "unexpected output event",
                      {cache_we, prog_go}, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.is_go) begin
                    check(prog_go && !cache_we, it.req, "program pulse", prog_go, 1);
                    check(prog_kind == it.kind, it.req, "program kind", prog_kind, it.kind);
                    check(row_addr == it.row, it.req, "row at program", row_addr, it.row);
                end else begin
                    check(cache_we && !prog_go, it.req, "cache write", cache_we, 1);
                    check(cache_addr == it.addr, it.req, "cache column", cache_addr, it.addr);
                    check(cache_wdata == it.data, it.req, "cache data", cache_wdata, it.data);
                end
            end
        end
    end

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            check(0, "watchdog", "run did not complete", 0, 1);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!cache_we && !prog_go, "R1", "strobes after reset", {cache_we, prog_go}, 0);
        check(row_addr == 0 && cache_addr == 0 && prog_kind == 0, "R1", "values after reset",
              {row_addr, cache_addr, prog_kind}, 0);

        // R2 setup and sequential data, R7 page program
        setup80(16'h0123, 24'h01ABCD);
        dat_exp(8'hA1, "R2"); dat_exp(8'hA2, "R2"); dat_exp(8'hA3, "R2");
        go_exp(8'h10, 2'd0, "R7 page");
        @(negedge clk);
        check(row_addr == 17'h1ABCD, "R2", "row after setup", row_addr, 17'h1ABCD);

        // R3 column-only redirect, R7 cache program
        setup80(16'h0010, 24'h000222);
        dat_exp(8'h11, "R3"); dat_exp(8'h12, "R3");
        cmd(8'h85); adr(8'h40); adr(8'h02);
        exp_col = 12'h240;
        dat_exp(8'h13, "R3"); dat_exp(8'h14, "R3");
        go_exp(8'h15, 2'd1, "R3/R7 cache");

        // R4 column plus row redirect, R7 multi-plane
        setup80(16'h0005, 24'h000333);
        dat_exp(8'h21, "R4");
        cmd(8'h85); adr(8'h00); adr(8'h01); adr(8'h44); adr(8'h55); adr(8'h01);
        exp_col = 12'h100; exp_row = 17'h15544;
        dat_exp(8'h22, "R4");
        go_exp(8'h11, 2'd2, "R4/R7 multi");

        // R5 redirect accepted during a background cache program
        setup80(16'h0000, 24'h000444);
        dat_exp(8'h31, "R5");
        go_exp(8'h15, 2'd1, "R5");
        ardy = 1'b0;
        setup80(16'h0060, 24'h000555);
        dat_exp(8'h32, "R5");
        cmd(8'h85); adr(8'h80); adr(8'h00);
        exp_col = 12'h080;
        dat_exp(8'h33, "R5");
        go_exp(8'h10, 2'd0, "R5");
        // R5 with no sequence open and ardy low: nothing may follow
        cmd(8'h85); adr(8'h01); adr(8'h00); adr(8'h01); adr(8'h02); adr(8'h00);
        dat(8'h34); cmd(8'h10);
        repeat (2) @(posedge clk);
        ardy = 1'b1;
        check(sb.size() == 0, "R5", "pending items after ignored 85h", sb.size(), 0);

        // R6 cycles while busy are ignored
        setup80(16'h0200, 24'h000666);
        dat_exp(8'h41, "R6");
        @(posedge clk); #1 rdy = 1'b0;
        cmd(8'h85); adr(8'h00); adr(8'h00); dat(8'h99); cmd(8'h10);
        @(posedge clk); #1 rdy = 1'b1;
        dat_exp(8'h42, "R6");
        go_exp(8'h10, 2'd0, "R6");

        // R8 incomplete row form behaves as column-only
        setup80(16'h0000, 24'h000777);
        cmd(8'h85); adr(8'h30); adr(8'h00); adr(8'h99);
        exp_col = 12'h030;
        dat_exp(8'h51, "R8");
        go_exp(8'h10, 2'd0, "R8 row kept");

        // R9 internal-data-move setup
        cmd(8'h85); adr(8'h20); adr(8'h00); adr(8'h88); adr(8'h08); adr(8'h00);
        exp_col = 12'h020; exp_row = 17'h00888;
        dat_exp(8'h61, "R9");
        cmd(8'h15);
        dat(8'h62);
        cmd(8'h85); adr(8'h20); adr(8'h00); adr(8'h88); adr(8'h08); adr(8'h00);
        exp_col = 12'h020;
        dat_exp(8'h63, "R9");
        cmd(8'h11);
        cmd(8'h85); adr(8'h24); adr(8'h00); adr(8'h99); adr(8'h09); adr(8'h01);
        exp_col = 12'h024; exp_row = 17'h10999;
        dat_exp(8'h64, "R9");
        go_exp(8'h10, 2'd0, "R9");

        // R10 unrelated command closes the sequence
        setup80(16'h0300, 24'h000AAA);
        dat_exp(8'h71, "R10");
        cmd(8'h70);
        dat(8'h72); cmd(8'h10);
        repeat (2) @(posedge clk);
        check(sb.size() == 0, "R10", "pending items after abort", sb.size(), 0);

        // R11 data before the column is complete is ignored
        cmd(8'h80); adr(8'h40); adr(8'h00); dat(8'hEE);
        adr(8'hBB); adr(8'h0B); adr(8'h00);
        exp_col = 12'h040; exp_row = 17'h00BBB;
        dat_exp(8'h81, "R11");
        cmd(8'h85); adr(8'h50); dat(8'hEF); adr(8'h00);
        exp_col = 12'h050;
        dat_exp(8'h82, "R11");
        go_exp(8'h10, 2'd0, "R11");

        // R12 column wraps
        setup80(16'h0FFE, 24'h000CCC);
        dat_exp(8'h91, "R12"); dat_exp(8'h92, "R12"); dat_exp(8'h93, "R12");
        go_exp(8'h10, 2'd0, "R12");

        repeat (4) @(posedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        done = 1;
        finish_up();
    end

endmodule